// File: doc/BRIEF.md
# Condition and Status-Flag Unit

This block owns the processor's 16-bit status word and decides, for every instruction, whether its condition holds and whether it may commit. It compares a 3-bit condition selector against the stored negative, zero and carry flags. Signed ordering tests use only the negative and zero flags. The result is a combinational pass signal. A committing instruction whose condition holds may refresh the flags from the ALU result and carry, overwrite the segment byte, or raise the processor into kernel mode through a system call. If the condition fails, the instruction has no effect on the status word.

The status word packs four fields. Bit 15 is N, bit 14 is Z and bit 13 is C. Bit 12 is the mode bit, where 0 means user and 1 means kernel. Bits 11:8 hold the process id and bits 7:0 hold the segment selector. A separate kernel write port replaces the whole word at once. Every pin is a plain level or strobe sampled on the rising clock edge. There is no streaming interface, so no back-pressure applies.

Top module: `stat_cond_unit`

## Requirements
- R1: While reset is low, and right after it is released, the status word reads 16'h1000: kernel mode, with flags, process id and segment all zero.
- R2: Condition codes 0 to 3 behave as follows. Code 0 always passes. Code 1 passes when Z=1 and code 2 when Z=0. Code 3 passes when C=1.
- R3: Condition codes 4 to 7 behave as follows. Code 4 passes when N=0 and Z=0. Code 5 passes when N=0. Code 6 passes when N=1. Code 7 passes when N=1 or Z=1.
- R4: `cond_pass` is combinational. It reflects the current flags and `cond_code` in the same cycle, whatever the value of `commit`.
- R5: A flag update loads three values from the ALU inputs: N takes result bit 15, Z is set when the result is zero, and C takes `alu_carry`. The new flags are visible after the clock edge that commits the update.
- R6: The flags change only on a committed, passing instruction that raises `flag_upd` or `is_compare`. A compare updates the flags even when `flag_upd` is low.
- R7: A committed, passing segment write loads `seg_data` into bits 7:0 and leaves bits 15:8 unchanged.
- R8: A committed, passing `syscall` sets the mode bit to 1 and leaves the other bits unchanged.
- R9: When `commit` is high and the condition fails, the flags, segment and mode bit all keep their values.
- R10: `kwr_en` replaces all 16 bits with `kwr_data` on the next edge. It does so regardless of `commit` or the condition, and it overrides any flag update, segment write or system call in the same cycle.
- R11: Only a kernel write (R10) changes the process id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_code | input | 3 | Condition selector of the current instruction |
| alu_result | input | DATA_W | ALU result used for N and Z |
| alu_carry | input | 1 | ALU carry or overflow used for C |
| flag_upd | input | 1 | Instruction asks for a flag update |
| is_compare | input | 1 | Instruction is a compare, so the flags always update |
| commit | input | 1 | Instruction attempts to commit this cycle |
| seg_wr | input | 1 | Instruction is a segment change |
| seg_data | input | 8 | New segment selector |
| syscall | input | 1 | Instruction is a system call |
| kwr_en | input | 1 | Kernel write of the whole status word |
| kwr_data | input | 16 | Value for the kernel write |
| cond_pass | output | 1 | Condition holds for the current flags |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| kernel_mode | output | 1 | Mode bit, where 1 means kernel |
| proc_id | output | 4 | Process id field |
| seg_sel | output | 8 | Current segment selector |

## Verification
`cond_pass` is due in the same cycle as its inputs. The bench drives at the falling edge and reads it one nanosecond later, before any rising edge. The status outputs are due one edge after the strobe that changes them. The bench therefore compares them at the following falling edge against a reference word that it advances once per rising edge. Because each step samples exactly one edge after its stimulus, a one-cycle lag or a premature update shows up as a mismatch.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef struct packed {
    logic       n;
    logic       z;
    logic       c;
    logic       kmode;
    logic [3:0] pid;
    logic [7:0] seg;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
  localparam int SEG_W    = 8;
  localparam int PID_W    = 4;

  localparam status_t STATUS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, kmode: 1'b1,
                                       pid: '0, seg: '0};

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_ZSET   = 3'd1,
    CC_ZCLR   = 3'd2,
    CC_CSET   = 3'd3,
    CC_ABOVE  = 3'd4,
    CC_NONNEG = 3'd5,
    CC_NEG    = 3'd6,
    CC_NOTPOS = 3'd7
  } cond_e;

endpackage

// File: rtl/stat_cond_eval.sv
module stat_cond_eval
  import stat_pkg::*;
(
  input  cond_e code,
  input  logic  n,
  input  logic  z,
  input  logic  c,
  output logic  pass
);
  always_comb begin
    unique case (code)
      CC_ALWAYS: pass = 1'b1;
      CC_ZSET:   pass = z;
      CC_ZCLR:   pass = ~z;
      CC_CSET:   pass = c;
      CC_ABOVE:  pass = ~n & ~z;
      CC_NONNEG: pass = ~n;
      CC_NEG:    pass = n;
      CC_NOTPOS: pass = n | z;
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/stat_flag_gen.sv
module stat_flag_gen #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  output logic              n_new,
  output logic              z_new,
  output logic              c_new
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    n_new = result[MSB];
    z_new = (result == '0);
    c_new = carry;
  end
endmodule

// File: rtl/stat_word_reg.sv
module stat_word_reg
  import stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kwr_en,
  input  logic [STATUS_W-1:0] kwr_data,
  input  logic             flag_we,
  input  logic             n_new,
  input  logic             z_new,
  input  logic             c_new,
  input  logic             seg_we,
  input  logic [SEG_W-1:0] seg_new,
  input  logic             mode_set,
  output status_t          q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= STATUS_RESET;
    end else if (kwr_en) begin
      q <= status_t'(kwr_data);
    end else begin
      if (flag_we) begin
        q.n <= n_new;
        q.z <= z_new;
        q.c <= c_new;
      end
      if (seg_we)   q.seg   <= seg_new;
      if (mode_set) q.kmode <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_cond_unit.sv
module stat_cond_unit
  import stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cond_code,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              flag_upd,
  input  logic              is_compare,
  input  logic              commit,
  input  logic              seg_wr,
  input  logic [7:0]        seg_data,
  input  logic              syscall,
  input  logic              kwr_en,
  input  logic [15:0]       kwr_data,
  output logic              cond_pass,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              kernel_mode,
  output logic [3:0]        proc_id,
  output logic [7:0]        seg_sel
);
  status_t word_q;
  logic    pass_w, go, n_new, z_new, c_new;

  stat_cond_eval u_eval (
    .code (cond_e'(cond_code)),
    .n    (word_q.n),
    .z    (word_q.z),
    .c    (word_q.c),
    .pass (pass_w)
  );

  stat_flag_gen #(.DATA_W(DATA_W)) u_fgen (
    .result (alu_result),
    .carry  (alu_carry),
    .n_new  (n_new),
    .z_new  (z_new),
    .c_new  (c_new)
  );

  assign go = commit & pass_w;

  stat_word_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .kwr_en   (kwr_en),
    .kwr_data (kwr_data),
    .flag_we  (go & (flag_upd | is_compare)),
    .n_new    (n_new),
    .z_new    (z_new),
    .c_new    (c_new),
    .seg_we   (go & seg_wr),
    .seg_new  (seg_data),
    .mode_set (go & syscall),
    .q        (word_q)
  );

  assign cond_pass   = pass_w;
  assign flag_n      = word_q.n;
  assign flag_z      = word_q.z;
  assign flag_c      = word_q.c;
  assign kernel_mode = word_q.kmode;
  assign proc_id     = word_q.pid;
  assign seg_sel     = word_q.seg;
endmodule

// File: rtl/stat_cond_chk.sv
module stat_cond_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cond_code,
  input logic        flag_upd,
  input logic        is_compare,
  input logic        commit,
  input logic        seg_wr,
  input logic        syscall,
  input logic        kwr_en,
  input logic [15:0] kwr_data,
  input logic        cond_pass,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_c,
  input logic        kernel_mode,
  input logic [3:0]  proc_id,
  input logic [7:0]  seg_sel
);
  // R10
  kwr_whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kwr_en |=> {flag_n, flag_z, flag_c, kernel_mode, proc_id, seg_sel} == $past(kwr_data));

  // R9
  fail_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cond_pass && !kwr_en) |=>
      ($stable({flag_n, flag_z, flag_c}) && $stable(seg_sel) && $stable(kernel_mode)));

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kwr_en && !(commit && cond_pass && (flag_upd || is_compare))) |=>
      $stable({flag_n, flag_z, flag_c}));

  // R8
  syscall_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cond_pass && syscall && !kwr_en) |=> kernel_mode);

  // R11
  pid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kwr_en |=> $stable(proc_id));

  // R7
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kwr_en && !(commit && cond_pass && seg_wr)) |=> $stable(seg_sel));

  // R2
  always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 3'd0) |-> cond_pass);

  // R3
  sign_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 3'd5) |-> (cond_pass != flag_n));
endmodule

bind stat_cond_unit stat_cond_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cond_code   (cond_code),
  .flag_upd    (flag_upd),
  .is_compare  (is_compare),
  .commit      (commit),
  .seg_wr      (seg_wr),
  .syscall     (syscall),
  .kwr_en      (kwr_en),
  .kwr_data    (kwr_data),
  .cond_pass   (cond_pass),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .kernel_mode (kernel_mode),
  .proc_id     (proc_id),
  .seg_sel     (seg_sel)
);

// File: tb/sim_stat_cond_unit.sv
`timescale 1ns/1ps
module sim_stat_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cond_code = '0;
  logic [15:0] alu_result = '0;
  logic        alu_carry = 1'b0, flag_upd = 1'b0, is_compare = 1'b0, commit = 1'b0;
  logic        seg_wr = 1'b0, syscall = 1'b0, kwr_en = 1'b0;
  logic [7:0]  seg_data = '0;
  logic [15:0] kwr_data = '0;
  logic        cond_pass, flag_n, flag_z, flag_c, kernel_mode;
  logic [3:0]  proc_id;
  logic [7:0]  seg_sel;

  int n_run = 0, n_fail = 0;
  logic [15:0] m = 16'h1000;

  always #10 clk = ~clk;

  stat_cond_unit u0 (.*);

  function automatic logic ref_pass(input logic [2:0] cc, input logic [15:0] s);
    logic n, z, c;
    n = s[15]; z = s[14]; c = s[13];
    case (cc)
      3'd0: return 1'b1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return c;
      3'd4: return !n && !z;
      3'd5: return !n;
      3'd6: return n;
      default: return n || z;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_word(input string tag);
    chk({tag, " flags"}, {flag_n, flag_z, flag_c}, m[15:13]);
    chk({tag, " mode"}, kernel_mode, m[12]);
    chk({tag, " R11 pid"}, proc_id, m[11:8]);
    chk({tag, " seg"}, seg_sel, m[7:0]);
  endtask

  // Called at a falling edge; drives, checks cond_pass, runs one edge, checks word.
  task automatic step(input logic [2:0] cc, input logic [15:0] res, input logic cy,
                      input logic upd, input logic cmp, input logic cmt,
                      input logic sw, input logic [7:0] sd, input logic sc,
                      input logic kw, input logic [15:0] kd, input string tag);
    logic p;
    cond_code = cc; alu_result = res; alu_carry = cy; flag_upd = upd;
    is_compare = cmp; commit = cmt; seg_wr = sw; seg_data = sd; syscall = sc;
    kwr_en = kw; kwr_data = kd;
    #1;
    p = ref_pass(cc, m);
    chk((cc < 3'd4) ? "R2/R4 cond_pass" : "R3/R4 cond_pass", cond_pass, p);
    if (kw) m = kd;
    else begin
      if (cmt && p && (upd || cmp)) m[15:13] = {res[15], res == 16'h0, cy};
      if (cmt && p && sw) m[7:0] = sd;
      if (cmt && p && sc) m[12] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check_word(tag);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset word", {flag_n, flag_z, flag_c, kernel_mode, proc_id, seg_sel}, 32'h1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {flag_n, flag_z, flag_c, kernel_mode, proc_id, seg_sel}, 32'h1000);

    // R10: kernel write overrides a same-cycle flag update, segment write and syscall
    step(3'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 16'h45C3, "R10");
    step(3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1, 16'h0000, "R10");
    // R8: syscall from user mode
    step(3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b1, 1'b0, 16'h0, "R8");
    chk("R8 kernel after syscall", kernel_mode, 1'b1);
    // R5: negative result, then zero result with carry
    step(3'd0, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0, 1'b0, 16'h0, "R5");
    chk("R5 n set", {flag_n, flag_z, flag_c}, 3'b100);
    step(3'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0, 1'b0, 16'h0, "R5");
    chk("R5 z and c set", {flag_n, flag_z, flag_c}, 3'b011);
    // R6: no request leaves flags; compare alone updates them
    step(3'd0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0, 1'b0, 16'h0, "R6");
    step(3'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0, 1'b0, 1'b0, 16'h0, "R6");
    chk("R6 compare updated", {flag_n, flag_z, flag_c}, 3'b000);
    // R7: segment write touches only the low byte
    step(3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1, 16'h0A00, "R7");
    step(3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 16'h0, "R7");
    chk("R7 segment word", {kernel_mode, proc_id, seg_sel}, 13'h0A5A);
    // R9: Z set, then a failing not-zero instruction must do nothing
    step(3'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0, 1'b0, 16'h0, "R9");
    step(3'd2, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h77, 1'b1, 1'b0, 16'h0, "R9");
    chk("R9 unchanged", {flag_n, flag_z, flag_c, kernel_mode, seg_sel}, {3'b010, 1'b0, 8'h5A});
    // R2 R3 R4: every code against every flag pattern, commit low
    for (int f = 0; f < 8; f++) begin
      step(3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1,
           {f[2:0], 13'h0123}, "R10");
      for (int k = 0; k < 8; k++)
        step(k[2:0], 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hEE, 1'b1, 1'b0, 16'h0,
             "R4 no commit");
    end
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0], $urandom, r[3], r[4], (r[7:5] == 3'd0), (r[9:8] != 2'd0), r[10],
           r[18:11], (r[21:19] == 3'd0), (r[24:22] == 3'd0), $urandom,
           "R5/R6/R7/R8/R9/R10");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule